// File: doc/BRIEF.md
# Four-Requester Memory Arbiter with Refresh Timer

This block decides which of four requesters may drive a shared DRAM controller: an internal refresh source, a secondary-bus port, a VME port and a register port. Each external request, together with the block-transfer, lock and address-only indications, enters through a two-flop synchronizer. Grants are then issued one at a time under fixed priority. A grant stays with its owner until the owner lets go.

The refresh source combines two things. One is an interval timer that raises a refresh request every `REFRESH_CYCLES` clocks, which is 15 us at the default clock. The other is a pending counter. Address-only strobes from either bus also add a refresh request. The pending counter makes sure that a refresh held back by a block transfer is still served afterwards. A grant to the refresh source comes with a one-cycle command pulse that starts a CAS-before-RAS cycle. The DRAM controller reports the end of that cycle on `refr_done`.

Top module: `mem_arbiter4`

## Requirements
- R1: During reset and in the first cycle after it, `gnt` is 0 and `refr_cmd` is 0.
- R2: Every request, lock, block and address-only input passes through two flops. A request seen at clock edge k on an idle arbiter, with no higher claim, shows its grant after edge k+2.
- R3: `gnt` has at most one bit set. The bit positions are: bit 0 refresh, bit 1 secondary bus, bit 2 VME, bit 3 register port.
- R4: When the arbiter is idle, the winner is chosen in fixed order: a pending refresh, then the secondary bus, then VME, then the register port.
- R5: A grant is held while the owner keeps its request. After release the arbiter spends one cycle with no grant, and then arbitrates again.
- R6: The interval timer adds one refresh request every `REFRESH_CYCLES` clocks.
- R7: Refresh requests are counted, up to a limit of 2. Any further request while the count is full is lost.
- R8: A pending refresh is not granted while either synchronized block-transfer flag is high. It is granted once both flags are low.
- R9: The secondary bus is not granted while the synchronized VME lock or VME block flag is high.
- R10: A synchronized rising edge of either address-only strobe adds one refresh request.
- R11: `refr_cmd` is high for exactly the first cycle of each refresh grant.
- R12: A refresh grant is held until `refr_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vb_req | input | 1 | Secondary-bus port request |
| vme_req | input | 1 | VME port request |
| reg_req | input | 1 | Register port request |
| vme_lock | input | 1 | VME read-modify-write in progress |
| vme_blt | input | 1 | VME block transfer in progress |
| vb_blt | input | 1 | Secondary-bus block transfer in progress |
| ao_vme | input | 1 | VME address-only strobe |
| ao_vb | input | 1 | Secondary-bus address-only strobe |
| refr_done | input | 1 | DRAM controller has finished the refresh cycle |
| gnt | output | 4 | One-hot grant |
| refr_cmd | output | 1 | Start pulse for a CAS-before-RAS refresh |

## Verification
The assertions check on every cycle the properties that can be seen locally in time:
- grants are one-hot;
- no grant passes straight from one owner to another;
- the command pulse lines up with the start of a refresh grant;
- a refresh grant is held until done;
- no refresh starts during a block transfer;
- the secondary bus is never granted under VME lock;
- the pending count never passes its limit.

Some behaviour can only be shown by the bench's cycle-accurate model in its scenarios. This covers the exact priority outcome of contention, the two-cycle synchronizer delay, the timer period, and saturation losing the third deferred refresh. It also covers address-only strobes producing refreshes.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    OWN_NONE = 3'd0,
    OWN_REF  = 3'd1,
    OWN_VB   = 3'd2,
    OWN_VME  = 3'd3,
    OWN_REG  = 3'd4
  } owner_e;

  localparam int NUM_SYNC = 8;
  localparam int IX_VB_REQ  = 0;
  localparam int IX_VME_REQ = 1;
  localparam int IX_REG_REQ = 2;
  localparam int IX_LOCK    = 3;
  localparam int IX_VME_BLT = 4;
  localparam int IX_VB_BLT  = 5;
  localparam int IX_AO_VME  = 6;
  localparam int IX_AO_VB   = 7;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/arb_refresh_src.sv
module arb_refresh_src #(
  parameter int REFRESH_CYCLES = 1500,
  parameter int PEND_MAX       = 2,
  localparam int CNT_W  = $clog2(REFRESH_CYCLES),
  localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ao_lvl,
  input  logic              take,
  output logic              pend_nz,
  output logic [PEND_W-1:0] pend
);
  localparam int SUM_W = PEND_W + 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [1:0]        ao_prev_q;
  logic              tick;
  logic [1:0]        ao_edge;
  logic [SUM_W-1:0]  sum;

  assign tick    = (cnt_q == CNT_W'(REFRESH_CYCLES - 1));
  assign ao_edge = ao_lvl & ~ao_prev_q;

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    sum   = SUM_W'(pend_q) + SUM_W'(tick) + SUM_W'(ao_edge[0]) + SUM_W'(ao_edge[1])
            - SUM_W'(take);
    if (sum > SUM_W'(PEND_MAX)) pend_d = PEND_W'(PEND_MAX);
    else                        pend_d = sum[PEND_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pend_q    <= '0;
      ao_prev_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      pend_q    <= pend_d;
      ao_prev_q <= ao_lvl;
    end
  end

  assign pend_nz = (pend_q != '0);
  assign pend    = pend_q;
endmodule

// File: rtl/arb_core.sv
module arb_core
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pend,
  input  logic       vb_req,
  input  logic       vme_req,
  input  logic       reg_req,
  input  logic       lockout,
  input  logic       blt_any,
  input  logic       refr_done,
  output logic       take,
  output logic [3:0] gnt,
  output logic       refr_cmd
);
  owner_e owner_q, owner_d, pick;
  logic   cmd_q;

  always_comb begin
    pick = OWN_NONE;
    if (ref_pend && !blt_any)   pick = OWN_REF;
    else if (vb_req && !lockout) pick = OWN_VB;
    else if (vme_req)           pick = OWN_VME;
    else if (reg_req)           pick = OWN_REG;
  end

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: owner_d = pick;
      OWN_REF:  if (refr_done) owner_d = OWN_NONE;
      OWN_VB:   if (!vb_req)   owner_d = OWN_NONE;
      OWN_VME:  if (!vme_req)  owner_d = OWN_NONE;
      OWN_REG:  if (!reg_req)  owner_d = OWN_NONE;
      default:  owner_d = OWN_NONE;
    endcase
  end

  assign take = (owner_q == OWN_NONE) && (pick == OWN_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      cmd_q   <= 1'b0;
    end else begin
      owner_q <= owner_d;
      cmd_q   <= take;
    end
  end

  assign gnt = {owner_q == OWN_REG, owner_q == OWN_VME,
                owner_q == OWN_VB,  owner_q == OWN_REF};
  assign refr_cmd = cmd_q;
endmodule

// File: rtl/mem_arbiter4.sv
module mem_arbiter4
  import arb_pkg::*;
#(
  parameter int REFRESH_CYCLES = 1500,
  parameter int PEND_MAX       = 2,
  localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vb_req,
  input  logic       vme_req,
  input  logic       reg_req,
  input  logic       vme_lock,
  input  logic       vme_blt,
  input  logic       vb_blt,
  input  logic       ao_vme,
  input  logic       ao_vb,
  input  logic       refr_done,
  output logic [3:0] gnt,
  output logic       refr_cmd
);
  logic [NUM_SYNC-1:0] raw, syn;
  logic                lockout, blt_any, take, pend_nz;
  logic [PEND_W-1:0]   pend;

  assign raw = {ao_vb, ao_vme, vb_blt, vme_blt, vme_lock, reg_req, vme_req, vb_req};

  arb_sync #(.WIDTH(NUM_SYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign lockout = syn[IX_LOCK] | syn[IX_VME_BLT];
  assign blt_any = syn[IX_VME_BLT] | syn[IX_VB_BLT];

  arb_refresh_src #(.REFRESH_CYCLES(REFRESH_CYCLES), .PEND_MAX(PEND_MAX)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .ao_lvl({syn[IX_AO_VB], syn[IX_AO_VME]}),
    .take(take), .pend_nz(pend_nz), .pend(pend)
  );

  arb_core u_core (
    .clk(clk), .rst_n(rst_n), .ref_pend(pend_nz),
    .vb_req(syn[IX_VB_REQ]), .vme_req(syn[IX_VME_REQ]), .reg_req(syn[IX_REG_REQ]),
    .lockout(lockout), .blt_any(blt_any), .refr_done(refr_done),
    .take(take), .gnt(gnt), .refr_cmd(refr_cmd)
  );
endmodule

// File: rtl/mem_arbiter4_chk.sv
module mem_arbiter4_chk #(
  parameter int PEND_W   = 2,
  parameter int PEND_MAX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        gnt,
  input logic              refr_cmd,
  input logic              refr_done,
  input logic              lockout,
  input logic              blt_any,
  input logic [PEND_W-1:0] pend
);
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_no_direct_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) != 4'b0 && gnt != 4'b0) |-> (gnt == $past(gnt)));

  assert_cmd_starts_refresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refr_cmd |-> (gnt[0] && !$past(gnt[0])));

  assert_refresh_start_has_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt[0]) |-> refr_cmd);

  assert_refresh_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt[0]) && !$past(refr_done)) |-> gnt[0]);

  assert_no_refresh_in_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt[0]) |-> !$past(blt_any));

  assert_vb_locked_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt[1]) |-> !$past(lockout));

  assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PEND_W'(PEND_MAX));
endmodule

bind mem_arbiter4 mem_arbiter4_chk #(.PEND_W(PEND_W), .PEND_MAX(PEND_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .refr_cmd(refr_cmd), .refr_done(refr_done),
  .lockout(lockout), .blt_any(blt_any), .pend(pend)
);

// File: tb/mem_arbiter4_bench.sv
`timescale 1ns/1ps
module mem_arbiter4_bench;
  localparam int P = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic vb_req, vme_req, reg_req, vme_lock, vme_blt, vb_blt, ao_vme, ao_vb, refr_done;
  logic [3:0] gnt;
  logic refr_cmd;

  always #5 clk = ~clk;

  mem_arbiter4 #(.REFRESH_CYCLES(P)) u_mem_arbiter4 (
    .clk(clk), .rst_n(rst_n), .vb_req(vb_req), .vme_req(vme_req), .reg_req(reg_req),
    .vme_lock(vme_lock), .vme_blt(vme_blt), .vb_blt(vb_blt), .ao_vme(ao_vme),
    .ao_vb(ao_vb), .refr_done(refr_done), .gnt(gnt), .refr_cmd(refr_cmd)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  int m_cnt, m_pend, m_own;
  bit m_cmd;
  bit m_s1[8], m_s2[8], m_prev_ao[2];

  function automatic logic [3:0] own_to_gnt(int o);
    case (o)
      1: return 4'b0001;
      2: return 4'b0010;
      3: return 4'b0100;
      4: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_own = 0; m_cmd = 0;
      foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; end
      m_prev_ao[0] = 0; m_prev_ao[1] = 0;
    end else begin
      bit tick, blt, lock, take;
      int pick, edges;
      bit [7:0] inp;
      tick = (m_cnt == P - 1);
      m_cnt = tick ? 0 : m_cnt + 1;
      edges = int'(m_s2[6] && !m_prev_ao[0]) + int'(m_s2[7] && !m_prev_ao[1]);
      blt  = m_s2[4] || m_s2[5];
      lock = m_s2[3] || m_s2[4];
      pick = 0;
      if (m_pend > 0 && !blt)      pick = 1;
      else if (m_s2[0] && !lock)   pick = 2;
      else if (m_s2[1])            pick = 3;
      else if (m_s2[2])            pick = 4;
      take = (m_own == 0) && (pick == 1);
      m_pend = m_pend + int'(tick) + edges - int'(take);
      if (m_pend > 2) m_pend = 2;
      m_cmd = take;
      case (m_own)
        0: m_own = pick;
        1: if (refr_done) m_own = 0;
        2: if (!m_s2[0]) m_own = 0;
        3: if (!m_s2[1]) m_own = 0;
        4: if (!m_s2[2]) m_own = 0;
        default: m_own = 0;
      endcase
      m_prev_ao[0] = m_s2[6]; m_prev_ao[1] = m_s2[7];
      inp = {ao_vb, ao_vme, vb_blt, vme_blt, vme_lock, reg_req, vme_req, vb_req};
      foreach (m_s1[i]) begin m_s2[i] = m_s1[i]; m_s1[i] = inp[i]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if (gnt !== own_to_gnt(m_own) || refr_cmd !== m_cmd) begin
        n_bad++;
        $display("FAIL %s: gnt=%b refr_cmd=%b expected gnt=%b refr_cmd=%b at %0t",
                 tag, gnt, refr_cmd, own_to_gnt(m_own), m_cmd, $time);
      end
    end
  end

  // refresh completion responder: done after the grant has been seen 3 cycles (R12)
  initial begin
    int held = 0;
    refr_done = 1'b0;
    forever begin
      @(negedge clk);
      held = gnt[0] ? held + 1 : 0;
      refr_done = (held >= 3);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all();
    vb_req = 0; vme_req = 0; reg_req = 0; vme_lock = 0;
    vme_blt = 0; vb_blt = 0; ao_vme = 0; ao_vb = 0;
  endtask

  task automatic check(string t, logic [4:0] act, logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, act, exp);
    end
  endtask

  initial begin
    int k;
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int pulses;
    idle_all();
    rst_n = 1'b0;
    cyc(3);
    check("R1 reset", {gnt, refr_cmd}, 5'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {gnt, refr_cmd}, 5'b0);

    // R2 single requests, sync latency and hold
    tag = "R2"; cyc(5);
    vme_req = 1; cyc(12); vme_req = 0; cyc(6);
    tag = "R5"; vb_req = 1; cyc(9); vb_req = 0; cyc(5);
    reg_req = 1; cyc(7); reg_req = 0; cyc(6);

    // R4 contention, released one at a time
    tag = "R4";
    vb_req = 1; vme_req = 1; reg_req = 1; cyc(10);
    vb_req = 0; cyc(8); vme_req = 0; cyc(8); reg_req = 0; cyc(6);
    vme_req = 1; reg_req = 1; cyc(8); vme_req = 0; cyc(6); reg_req = 0; cyc(6);

    // R9 VME lock keeps secondary bus out
    tag = "R9";
    vme_lock = 1; vb_req = 1; reg_req = 1; cyc(20);
    reg_req = 0; cyc(10); vme_lock = 0; cyc(10); vb_req = 0; cyc(6);
    vme_blt = 1; vme_req = 1; vb_req = 1; cyc(12); vme_req = 0; cyc(10);
    vme_blt = 0; cyc(10); vb_req = 0; cyc(6);

    // R8/R7 deferral across a long block transfer, count saturates
    tag = "R8";
    vb_blt = 1; vb_req = 1; cyc(4 * P); vb_req = 0; cyc(6);
    tag = "R7"; vb_blt = 0; cyc(20);

    // R10 address-only strobes
    tag = "R10";
    ao_vme = 1; cyc(1); ao_vme = 0; cyc(12);
    ao_vb = 1; cyc(3); ao_vb = 0; cyc(12);
    ao_vme = 1; ao_vb = 1; cyc(2); ao_vme = 0; ao_vb = 0; cyc(20);

    // R6/R11/R12 period: count command pulses in an idle window
    tag = "R6"; cyc(2 * P);
    pulses = 0;
    for (int i = 0; i < 10 * P; i++) begin
      @(negedge clk);
      if (refr_cmd) pulses++;
    end
    check("R6 R11 pulses in 10 periods", 5'(pulses), 5'd10);

    // R12 refresh held while done is low, mixed with traffic
    tag = "R12";
    vme_req = 1; cyc(3 * P); vme_req = 0; cyc(10);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule